// File: doc/BRIEF.md
# Two-Bank GPIO Controller with Edge Interrupts

This block is a register-mapped general-purpose I/O controller for 64 pins, organised as two banks of 32. Pin `p` belongs to bank `p / 32` at bit `p % 32` of that bank's words. Software reads the pin levels, chooses per pin whether it is driven, and changes the output latch only through dedicated set and clear words. Bits written as 1 act; bits written as 0 do nothing. A two-bit function selector per pin is held for the pad multiplexer outside the block.

Every pin input is resynchronised by two flops before any use. Each pin can flag a rising edge, a falling edge or both into a sticky status word, and a single level interrupt is raised while any status bit is set. Software clears status bits by writing ones to them. The bus uses word addresses, and reads are combinational while `bus_rd` is high.

Word map (word address, bank 0 / bank 1): level 0/1, direction 2/3, set 4/5, clear 6/7, rise enable 8/9, fall enable 10/11, edge status 12/13, function select 14..17 (bank 0 pins 0-15, 16-31, then bank 1 pins 32-47, 48-63).

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every pin is an input (`pin_oe` all 0), the output latch, rise enables, fall enables, edge status and function selects are all 0, and `irq` is low.
- R2: Reading word 0 or 1 returns the pin levels of bank 0 or 1 after two synchroniser flops. A change on `pin_in` becomes visible on the second rising clock edge after it. Writes to these words are ignored.
- R3: Words 2 and 3 hold the direction bits. A 1 makes the pin an output and is reflected on `pin_oe`. The words read back as written.
- R4: A write to word 4 or 5 sets the latch bit (`pin_out`) for every data bit that is 1 and leaves bits written 0 unchanged. These words read as zero.
- R5: A write to word 6 or 7 clears the latch bit for every data bit that is 1 and leaves bits written 0 unchanged. These words read as zero.
- R6: When a pin's rise-enable bit (words 8/9) is 1, a synchronised low-to-high transition sets its edge-status bit (words 12/13). With the enable at 0, the transition leaves status unchanged.
- R7: When a pin's fall-enable bit (words 10/11) is 1, a synchronised high-to-low transition sets the same edge-status bit. A rising transition does not set it through this enable.
- R8: An edge-status bit stays set until a 1 is written to it. Writing 0 leaves it set.
- R9: If a detected edge and a write of 1 to the same status bit fall in the same cycle, the bit ends set.
- R10: Pin `p` has a two-bit function field at bit `(p % 16)*2` of function word `14 + p/16`, and this field drives `alt_sel[2p+1:2p]`. The words read back as written. Value 0 means plain GPIO.
- R11: `irq` is high exactly while at least one edge-status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read enable; `bus_rdata` is zero when low |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | 64 | Asynchronous pin levels |
| pin_out | output | 64 | Output latch |
| pin_oe | output | 64 | Output enable, 1 = drive |
| alt_sel | output | 128 | Two-bit function select per pin |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that at most one word is written per cycle and that the address of a write is stable across the sampling edge. They also assume that `pin_in` is held for at least three clock cycles between changes that are meant to produce one edge each. The bench meets these assumptions by changing pins and bus signals only on falling clock edges, issuing one write per task step, and waiting three cycles after each pin change before sampling. The same-cycle clash of an edge and a clearing write is lined up by counting the synchroniser stages, not by relaxing those limits.

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl #(
  parameter int NUM_PINS = 64,
  localparam int NB = NUM_PINS / 32,
  localparam int AW = $clog2(9 * NB)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [AW-1:0]         bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NUM_PINS-1:0]   pin_in,
  output logic [NUM_PINS-1:0]   pin_out,
  output logic [NUM_PINS-1:0]   pin_oe,
  output logic [2*NUM_PINS-1:0] alt_sel,
  output logic                  irq
);

  localparam int OFF_LVL  = 0;
  localparam int OFF_DIR  = NB;
  localparam int OFF_SET  = 2 * NB;
  localparam int OFF_CLR  = 3 * NB;
  localparam int OFF_RISE = 4 * NB;
  localparam int OFF_FALL = 5 * NB;
  localparam int OFF_STAT = 6 * NB;
  localparam int OFF_ALT  = 7 * NB;
  localparam int NALT     = 2 * NB;

  logic [NUM_PINS-1:0]   sync1_q, sync2_q, prev_q;
  logic [NUM_PINS-1:0]   dir_q, out_q, rise_en_q, fall_en_q, stat_q;
  logic [2*NUM_PINS-1:0] alt_q;
  logic [NUM_PINS-1:0]   set_mask, clr_mask, ack_mask, edge_hit;
  logic [31:0]           rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign edge_hit = (sync2_q & ~prev_q & rise_en_q) | (~sync2_q & prev_q & fall_en_q);

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    ack_mask = '0;
    for (int b = 0; b < NB; b++) begin
      if (bus_wr && bus_addr == AW'(OFF_SET + b))  set_mask[b*32 +: 32] = bus_wdata;
      if (bus_wr && bus_addr == AW'(OFF_CLR + b))  clr_mask[b*32 +: 32] = bus_wdata;
      if (bus_wr && bus_addr == AW'(OFF_STAT + b)) ack_mask[b*32 +: 32] = bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q     <= '0;
      out_q     <= '0;
      rise_en_q <= '0;
      fall_en_q <= '0;
      stat_q    <= '0;
      alt_q     <= '0;
    end else begin
      out_q  <= (out_q | set_mask) & ~clr_mask;
      stat_q <= (stat_q & ~ack_mask) | edge_hit;
      for (int b = 0; b < NB; b++) begin
        if (bus_wr && bus_addr == AW'(OFF_DIR + b))  dir_q[b*32 +: 32]     <= bus_wdata;
        if (bus_wr && bus_addr == AW'(OFF_RISE + b)) rise_en_q[b*32 +: 32] <= bus_wdata;
        if (bus_wr && bus_addr == AW'(OFF_FALL + b)) fall_en_q[b*32 +: 32] <= bus_wdata;
      end
      for (int w = 0; w < NALT; w++)
        if (bus_wr && bus_addr == AW'(OFF_ALT + w)) alt_q[w*32 +: 32] <= bus_wdata;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int b = 0; b < NB; b++) begin
      if (bus_addr == AW'(OFF_LVL + b))  rd_word = sync2_q[b*32 +: 32];
      if (bus_addr == AW'(OFF_DIR + b))  rd_word = dir_q[b*32 +: 32];
      if (bus_addr == AW'(OFF_RISE + b)) rd_word = rise_en_q[b*32 +: 32];
      if (bus_addr == AW'(OFF_FALL + b)) rd_word = fall_en_q[b*32 +: 32];
      if (bus_addr == AW'(OFF_STAT + b)) rd_word = stat_q[b*32 +: 32];
    end
    for (int w = 0; w < NALT; w++)
      if (bus_addr == AW'(OFF_ALT + w)) rd_word = alt_q[w*32 +: 32];
  end

  assign bus_rdata = bus_rd ? rd_word : '0;
  assign pin_out   = out_q;
  assign pin_oe    = dir_q;
  assign alt_sel   = alt_q;
  assign irq       = |stat_q;

  for (genvar b = 0; b < NB; b++) begin : g_bank_chk
    // R4
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == AW'(OFF_SET + b)) |=>
        ((pin_out[b*32 +: 32] & $past(bus_wdata)) == $past(bus_wdata)));
    // R5
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == AW'(OFF_CLR + b)) |=>
        ((pin_out[b*32 +: 32] & $past(bus_wdata)) == 32'h0));
  end

  // R4
  out_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(pin_out));

  // R3
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(pin_oe));

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(stat_q & ~ack_mask)) == $past(stat_q & ~ack_mask)));

  // R9
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit != '0) |=> ((stat_q & $past(edge_hit)) == $past(edge_hit)));

  // R11
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !bus_wr) |=> irq);

endmodule

// File: tb/gpio_bank_ctrl_tb_top.sv
module gpio_bank_ctrl_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0;
  logic         bus_rd = 1'b0;
  logic [4:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [63:0]  pin_in = '0;
  logic [63:0]  pin_out, pin_oe;
  logic [127:0] alt_sel;
  logic         irq;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  gpio_bank_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .alt_sel(alt_sel), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_addr = 5'(a); bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp, input string req);
    bus_addr = 5'(a); bus_rd = 1'b1;
    #1;
    chk(bus_rdata == exp, req, bus_rdata, exp);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(pin_oe == '0, "R1 oe", pin_oe, 0);
    chk(pin_out == '0, "R1 out", pin_out, 0);
    chk(alt_sel == '0, "R1 alt", alt_sel, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    rd_chk(2, 0, "R1 dir0");
    rd_chk(9, 0, "R1 rise1");
    rd_chk(13, 0, "R1 stat1");
  endtask

  task automatic t_level;
    pin_in = {32'hA5A5_0F0F, 32'h1234_5678};
    idle(1);
    rd_chk(0, 32'h0, "R2 one edge not yet visible");
    idle(1);
    rd_chk(0, 32'h1234_5678, "R2 level0");
    rd_chk(1, 32'hA5A5_0F0F, "R2 level1");
    wr(0, 32'hFFFF_FFFF);
    rd_chk(0, 32'h1234_5678, "R2 write ignored");
    pin_in = '0;
    idle(3);
    rd_chk(12, 0, "R6 disabled edges leave status");
    rd_chk(13, 0, "R6 disabled edges leave status bank1");
  endtask

  task automatic t_dir;
    wr(2, 32'hF0F0_0001);
    wr(3, 32'h8000_0000);
    rd_chk(2, 32'hF0F0_0001, "R3 dir0");
    rd_chk(3, 32'h8000_0000, "R3 dir1");
    chk(pin_oe == 64'h8000_0000_F0F0_0001, "R3 oe", pin_oe, 64'h8000_0000_F0F0_0001);
  endtask

  task automatic t_setclr;
    wr(4, 32'h0000_00FF);
    chk(pin_out == 64'h0000_0000_0000_00FF, "R4 set0", pin_out, 64'hFF);
    wr(5, 32'h8000_0001);
    chk(pin_out == 64'h8000_0001_0000_00FF, "R4 set1", pin_out, 64'h8000_0001_0000_00FF);
    wr(4, 32'h0);
    chk(pin_out == 64'h8000_0001_0000_00FF, "R4 zero write", pin_out, 64'h8000_0001_0000_00FF);
    wr(6, 32'h0000_000F);
    chk(pin_out == 64'h8000_0001_0000_00F0, "R5 clr0", pin_out, 64'h8000_0001_0000_00F0);
    wr(6, 32'h0);
    chk(pin_out == 64'h8000_0001_0000_00F0, "R5 zero write", pin_out, 64'h8000_0001_0000_00F0);
    wr(7, 32'h0000_0001);
    chk(pin_out == 64'h8000_0000_0000_00F0, "R5 clr1", pin_out, 64'h8000_0000_0000_00F0);
    rd_chk(5, 0, "R4 set reads zero");
    rd_chk(6, 0, "R5 clr reads zero");
  endtask

  task automatic t_rise;
    wr(8, 32'h0000_0008);
    pin_in[3] = 1'b1;
    idle(3);
    rd_chk(12, 32'h8, "R6 rise sets status");
    chk(irq == 1'b1, "R11 irq on", irq, 1);
    pin_in[3] = 1'b0;
    idle(3);
    rd_chk(12, 32'h8, "R8 sticky, no fall enable");
    wr(12, 32'h0);
    rd_chk(12, 32'h8, "R8 zero write keeps");
    chk(irq == 1'b1, "R11 irq held", irq, 1);
    wr(12, 32'h8);
    rd_chk(12, 32'h0, "R8 one clears");
    chk(irq == 1'b0, "R11 irq off", irq, 0);
  endtask

  task automatic t_fall;
    wr(11, 32'h0000_0100);
    pin_in[40] = 1'b1;
    idle(3);
    rd_chk(13, 32'h0, "R7 rise ignored by fall enable");
    pin_in[40] = 1'b0;
    idle(3);
    rd_chk(13, 32'h100, "R7 fall sets status");
    chk(irq == 1'b1, "R11 irq from bank1", irq, 1);
    wr(13, 32'h100);
    chk(irq == 1'b0, "R11 irq cleared", irq, 0);
  endtask

  task automatic t_collide;
    wr(8, 32'h0000_0020);
    wr(10, 32'h0000_0020);
    pin_in[5] = 1'b1;
    idle(3);
    rd_chk(12, 32'h20, "R6 pin5 rise");
    pin_in[5] = 1'b0;
    idle(2);
    wr(12, 32'h20);
    rd_chk(12, 32'h20, "R9 edge beats clear");
    chk(irq == 1'b1, "R9 irq stays", irq, 1);
    wr(12, 32'h20);
    rd_chk(12, 32'h0, "R8 later clear");
  endtask

  task automatic t_alt;
    wr(17, 32'h0000_0008);
    chk(alt_sel[99:98] == 2'd2, "R10 pin49 field", alt_sel[99:98], 2);
    rd_chk(17, 32'h8, "R10 readback");
    wr(14, 32'hC000_0001);
    chk(alt_sel[31:30] == 2'd3, "R10 pin15 field", alt_sel[31:30], 3);
    chk(alt_sel[1:0] == 2'd1, "R10 pin0 field", alt_sel[1:0], 1);
    chk(alt_sel[95:32] == '0, "R10 other words", alt_sel[95:32], 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset;
    t_level;
    t_dir;
    t_setclr;
    t_rise;
    t_fall;
    t_collide;
    t_alt;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule